// File: doc/BRIEF.md
# Ternary-Match Fast-Path Forwarding Engine

This block decides, for every received frame, whether it can be forwarded directly to a peer network card or must go to host memory for software routing. The parser ahead of it presents the Ethernet type, the destination IP address, the TTL byte, the current IPv4 header checksum and the Ethernet destination MAC, together with a one-cycle lookup strobe. The engine compares the destination address against a small table of ternary entries. Each entry holds a value and a care-mask, the index of a peer card and the MAC address of the next-hop router.

A hit on an IPv4 frame selects the fast path. The destination MAC is replaced by the entry's next-hop MAC, the TTL is lowered by one, and the header checksum is updated incrementally with ones-complement arithmetic. A frame whose TTL would reach zero is dropped instead. A miss, or a frame that is not IPv4, goes to the slow path with its fields untouched. The table is written one entry at a time through a simple write port. All results are registered and appear one cycle after the strobe.

Top module: `fastpath_fwd_engine`

## Requirements
- R1: After reset `res_valid` is low and every table entry is disabled, so any lookup before the first table write goes to the slow path.
- R2: An enabled entry matches when every address bit whose care-mask bit is 1 equals the entry value bit. Bits whose mask bit is 0 are ignored, so an all-zero mask matches every address.
- R3: An entry written with its enable bit at 0 never matches.
- R4: When several enabled entries match, the entry with the lowest index is selected.
- R5: Only an Ethernet type of 0x0800 (IPv4) is looked up. Any other type gives `res_slow` with MAC, TTL and checksum passed through unchanged and with `res_entry` and `res_peer` at 0.
- R6: An IPv4 frame that matches no entry gives `res_slow` with MAC, TTL and checksum unchanged and with `res_entry` and `res_peer` at 0.
- R7: An IPv4 hit with TTL of 2 or more gives `res_fast`. `res_entry` and `res_peer` report the selected entry and its peer index, `res_dst_mac` holds that entry's next-hop MAC, and `res_ttl` equals the input TTL minus 1.
- R8: On `res_fast`, `res_csum` equals the full ones-complement checksum of the IPv4 header recomputed with the decremented TTL.
- R9: An IPv4 hit with TTL 0 or 1 gives `res_drop` and never `res_fast`. MAC, TTL and checksum are passed through, and `res_entry` and `res_peer` are 0.
- R10: `res_valid` is high exactly in the cycle after a cycle with `lk_strobe` high. When it is high, exactly one of `res_fast`, `res_slow` and `res_drop` is high.
- R11: When `cfg_we` is high, the entry selected by `cfg_idx` is loaded with enable, value, mask, peer and MAC. An index at or above the entry count leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_valid | input | 1 | Enable bit for the written entry |
| cfg_value | input | 32 | Ternary compare value |
| cfg_mask | input | 32 | Care-mask, 1 = bit compared |
| cfg_peer | input | PEER_W | Destination peer index |
| cfg_mac | input | 48 | Next-hop MAC address |
| lk_strobe | input | 1 | Lookup request |
| lk_ethertype | input | 16 | Ethernet type of the frame |
| lk_dst_ip | input | 32 | IPv4 destination address |
| lk_ttl | input | 8 | IPv4 TTL |
| lk_csum | input | 16 | IPv4 header checksum as received |
| lk_dst_mac | input | 48 | Ethernet destination MAC as received |
| res_valid | output | 1 | Result valid |
| res_fast | output | 1 | Forward on the fast path |
| res_slow | output | 1 | Send to the slow path unchanged |
| res_drop | output | 1 | Discard, TTL expired |
| res_entry | output | IDX_W | Selected table entry |
| res_peer | output | PEER_W | Selected peer index |
| res_dst_mac | output | 48 | Outgoing destination MAC |
| res_ttl | output | 8 | Outgoing TTL |
| res_csum | output | 16 | Outgoing header checksum |

## Verification
The hardest corner to reach is the incremental checksum near ones-complement wrap-around, where the updated sum folds through 0xFFFF. The bench reaches it by building synthetic IPv4 headers whose other words are derived from a seed, and by sweeping every TTL value from 0 to 255 together with many seeds. For each case it recomputes the full header checksum and compares it with the output. Priority between overlapping entries is reached by loading a narrower entry inside a wider one and then disabling the wider entry with a rewrite. An out-of-range table write is probed by checking that a later lookup still misses.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    localparam int ADDR_W  = 32;
    localparam int MAC_W   = 48;
    localparam int TTL_W   = 8;
    localparam int CSUM_W  = 16;
    localparam int ETYPE_W = 16;

    localparam logic [ETYPE_W-1:0] ETYPE_IPV4 = 16'h0800;
    // ones-complement of 0x0100 (the TTL byte weight)
    localparam logic [31:0] TTL_DEC_ADD = 32'h0000_FEFF;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] value;
        logic [ADDR_W-1:0] mask;
        logic [MAC_W-1:0]  mac;
    } route_t;

    typedef enum logic [1:0] {
        PATH_SLOW = 2'd0,
        PATH_FAST = 2'd1,
        PATH_DROP = 2'd2
    } path_e;

    function automatic logic [CSUM_W-1:0] oc_fold(input logic [31:0] s);
        logic [31:0] t;
        t = {16'h0, s[15:0]} + {16'h0, s[31:16]};
        t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
        return t[15:0];
    endfunction

    // HC' = ~(~HC + ~m + m') with m - m' = 0x0100
    function automatic logic [CSUM_W-1:0] csum_after_ttl_dec(input logic [CSUM_W-1:0] c);
        return ~oc_fold({16'h0, ~c} + TTL_DEC_ADD);
    endfunction

    function automatic logic ternary_hit(input logic [ADDR_W-1:0] key,
                                         input route_t e);
        return e.en && (((key ^ e.value) & e.mask) == '0);
    endfunction

endpackage

// File: rtl/fpe_route_table.sv
module fpe_route_table
    import fpe_pkg::*;
#(
    parameter int NUM_ENTRIES = 3,
    parameter int IDX_W       = 2,
    parameter int PEER_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  route_t            wr_route,
    input  logic [PEER_W-1:0] wr_peer,
    output route_t            routes [NUM_ENTRIES],
    output logic [PEER_W-1:0] peers  [NUM_ENTRIES]
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                routes[i] <= '0;
                peers[i]  <= '0;
            end else if (sel) begin
                routes[i] <= wr_route;
                peers[i]  <= wr_peer;
            end
        end
    end

endmodule

// File: rtl/fpe_match.sv
module fpe_match
    import fpe_pkg::*;
#(
    parameter int NUM_ENTRIES = 3,
    parameter int IDX_W       = 2,
    parameter int PEER_W      = 2
) (
    input  logic [ADDR_W-1:0] key,
    input  route_t            routes [NUM_ENTRIES],
    input  logic [PEER_W-1:0] peers  [NUM_ENTRIES],
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [PEER_W-1:0] hit_peer,
    output logic [MAC_W-1:0]  hit_mac
);

    logic [NUM_ENTRIES-1:0] hv;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        assign hv[i] = ternary_hit(key, routes[i]);
    end

    // scan from the top so the lowest matching index is kept last
    always_comb begin
        hit      = |hv;
        hit_idx  = '0;
        hit_peer = '0;
        hit_mac  = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit_idx  = IDX_W'(i);
                hit_peer = peers[i];
                hit_mac  = routes[i].mac;
            end
        end
    end

endmodule

// File: rtl/fpe_rewrite.sv
module fpe_rewrite
    import fpe_pkg::*;
(
    input  logic [TTL_W-1:0]  ttl_in,
    input  logic [CSUM_W-1:0] csum_in,
    output logic              expired,
    output logic [TTL_W-1:0]  ttl_out,
    output logic [CSUM_W-1:0] csum_out
);

    assign expired  = (ttl_in <= TTL_W'(1));
    assign ttl_out  = ttl_in - TTL_W'(1);
    assign csum_out = csum_after_ttl_dec(csum_in);

endmodule

// File: rtl/fastpath_fwd_engine.sv
module fastpath_fwd_engine
    import fpe_pkg::*;
#(
    parameter int  NUM_ENTRIES = 3,
    parameter int  PEER_W      = 2,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_valid,
    input  logic [31:0]        cfg_value,
    input  logic [31:0]        cfg_mask,
    input  logic [PEER_W-1:0]  cfg_peer,
    input  logic [47:0]        cfg_mac,
    input  logic               lk_strobe,
    input  logic [15:0]        lk_ethertype,
    input  logic [31:0]        lk_dst_ip,
    input  logic [7:0]         lk_ttl,
    input  logic [15:0]        lk_csum,
    input  logic [47:0]        lk_dst_mac,
    output logic               res_valid,
    output logic               res_fast,
    output logic               res_slow,
    output logic               res_drop,
    output logic [IDX_W-1:0]   res_entry,
    output logic [PEER_W-1:0]  res_peer,
    output logic [47:0]        res_dst_mac,
    output logic [7:0]         res_ttl,
    output logic [15:0]        res_csum
);

    route_t            routes [NUM_ENTRIES];
    logic [PEER_W-1:0] peers  [NUM_ENTRIES];
    route_t            wr_route;

    assign wr_route = '{en: cfg_valid, value: cfg_value, mask: cfg_mask, mac: cfg_mac};

    fpe_route_table #(
        .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .PEER_W(PEER_W)
    ) table_i (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_route(wr_route), .wr_peer(cfg_peer),
        .routes(routes), .peers(peers)
    );

    logic              m_hit;
    logic [IDX_W-1:0]  m_idx;
    logic [PEER_W-1:0] m_peer;
    logic [MAC_W-1:0]  m_mac;

    fpe_match #(
        .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .PEER_W(PEER_W)
    ) match_i (
        .key(lk_dst_ip), .routes(routes), .peers(peers),
        .hit(m_hit), .hit_idx(m_idx), .hit_peer(m_peer), .hit_mac(m_mac)
    );

    logic              rw_expired;
    logic [TTL_W-1:0]  rw_ttl;
    logic [CSUM_W-1:0] rw_csum;

    fpe_rewrite rewrite_i (
        .ttl_in(lk_ttl), .csum_in(lk_csum),
        .expired(rw_expired), .ttl_out(rw_ttl), .csum_out(rw_csum)
    );

    path_e path;
    always_comb begin
        if (!(m_hit && lk_ethertype == ETYPE_IPV4)) path = PATH_SLOW;
        else if (rw_expired)                         path = PATH_DROP;
        else                                         path = PATH_FAST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_fast    <= 1'b0;
            res_slow    <= 1'b0;
            res_drop    <= 1'b0;
            res_entry   <= '0;
            res_peer    <= '0;
            res_dst_mac <= '0;
            res_ttl     <= '0;
            res_csum    <= '0;
        end else begin
            res_valid <= lk_strobe;
            if (lk_strobe) begin
                res_fast <= (path == PATH_FAST);
                res_slow <= (path == PATH_SLOW);
                res_drop <= (path == PATH_DROP);
                if (path == PATH_FAST) begin
                    res_entry   <= m_idx;
                    res_peer    <= m_peer;
                    res_dst_mac <= m_mac;
                    res_ttl     <= rw_ttl;
                    res_csum    <= rw_csum;
                end else begin
                    res_entry   <= '0;
                    res_peer    <= '0;
                    res_dst_mac <= lk_dst_mac;
                    res_ttl     <= lk_ttl;
                    res_csum    <= lk_csum;
                end
            end
        end
    end

endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
    parameter int IDX_W  = 2,
    parameter int PEER_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_strobe,
    input logic [15:0]       lk_ethertype,
    input logic [7:0]        lk_ttl,
    input logic [15:0]       lk_csum,
    input logic [47:0]       lk_dst_mac,
    input logic              res_valid,
    input logic              res_fast,
    input logic              res_slow,
    input logic              res_drop,
    input logic [47:0]       res_dst_mac,
    input logic [7:0]        res_ttl,
    input logic [15:0]       res_csum
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !res_valid);

    assert_valid_timing_R10: assert property (@(posedge clk) disable iff (rst)
        lk_strobe |=> res_valid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !lk_strobe |=> !res_valid);

    assert_single_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($countones({res_fast, res_slow, res_drop}) == 1));

    assert_non_ipv4_untouched_R5: assert property (@(posedge clk) disable iff (rst)
        (lk_strobe && lk_ethertype != 16'h0800) |=>
            (res_slow && res_ttl == $past(lk_ttl) && res_csum == $past(lk_csum)
             && res_dst_mac == $past(lk_dst_mac)));

    assert_fast_ttl_dec_R7: assert property (@(posedge clk) disable iff (rst)
        lk_strobe |=> (!res_fast || ($past(lk_ttl) > 8'd1 && res_ttl == $past(lk_ttl) - 8'd1)));

    assert_expired_not_fast_R9: assert property (@(posedge clk) disable iff (rst)
        (lk_strobe && lk_ttl <= 8'd1) |=> !res_fast);

endmodule

bind fastpath_fwd_engine fpe_checker #(.IDX_W(IDX_W), .PEER_W(PEER_W)) chk_i (
    .clk(clk), .rst(rst), .lk_strobe(lk_strobe), .lk_ethertype(lk_ethertype),
    .lk_ttl(lk_ttl), .lk_csum(lk_csum), .lk_dst_mac(lk_dst_mac),
    .res_valid(res_valid), .res_fast(res_fast), .res_slow(res_slow), .res_drop(res_drop),
    .res_dst_mac(res_dst_mac), .res_ttl(res_ttl), .res_csum(res_csum)
);

// File: tb/fastpath_fwd_engine_tb.sv
module fastpath_fwd_engine_tb_top;

    localparam int N  = 3;
    localparam int IW = 2;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic          cfg_valid = 1'b0;
    logic [31:0]   cfg_value = '0;
    logic [31:0]   cfg_mask = '0;
    logic [PW-1:0] cfg_peer = '0;
    logic [47:0]   cfg_mac = '0;
    logic          lk_strobe = 1'b0;
    logic [15:0]   lk_ethertype = '0;
    logic [31:0]   lk_dst_ip = '0;
    logic [7:0]    lk_ttl = '0;
    logic [15:0]   lk_csum = '0;
    logic [47:0]   lk_dst_mac = '0;
    logic          res_valid, res_fast, res_slow, res_drop;
    logic [IW-1:0] res_entry;
    logic [PW-1:0] res_peer;
    logic [47:0]   res_dst_mac;
    logic [7:0]    res_ttl;
    logic [15:0]   res_csum;

    always #10 clk = ~clk;

    fastpath_fwd_engine #(.NUM_ENTRIES(N), .PEER_W(PW)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_value(cfg_value),
        .cfg_mask(cfg_mask), .cfg_peer(cfg_peer), .cfg_mac(cfg_mac),
        .lk_strobe(lk_strobe), .lk_ethertype(lk_ethertype), .lk_dst_ip(lk_dst_ip),
        .lk_ttl(lk_ttl), .lk_csum(lk_csum), .lk_dst_mac(lk_dst_mac),
        .res_valid(res_valid), .res_fast(res_fast), .res_slow(res_slow), .res_drop(res_drop),
        .res_entry(res_entry), .res_peer(res_peer), .res_dst_mac(res_dst_mac),
        .res_ttl(res_ttl), .res_csum(res_csum)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // bench model of the table
    logic        m_en   [N];
    logic [31:0] m_val  [N];
    logic [31:0] m_msk  [N];
    logic [1:0]  m_peer [N];
    logic [47:0] m_mac  [N];

    function automatic logic [15:0] fold(input logic [31:0] s);
        logic [31:0] t;
        t = {16'h0, s[15:0]} + {16'h0, s[31:16]};
        t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
        return t[15:0];
    endfunction

    // full checksum of a 20-byte header; word 4 carries TTL, word 5 is the checksum slot
    function automatic logic [15:0] hdr_csum(input logic [7:0] ttl, input int seed);
        logic [31:0] s;
        s = 32'h4500 + {16'h0, ttl, 8'h11};
        for (int k = 1; k < 10; k++) begin
            if (k != 4 && k != 5) s = s + 32'((seed * 40503 + k * 32587 + seed * k * 7) & 16'hFFFF);
        end
        return ~fold(s);
    endfunction

    task automatic check(input string tag, input logic [113:0] act, input logic [113:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_entry(input logic [IW-1:0] idx, input logic en, input logic [31:0] v,
                               input logic [31:0] m, input logic [1:0] p, input logic [47:0] mac);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_valid = en; cfg_value = v;
        cfg_mask = m; cfg_peer = p; cfg_mac = mac;
        @(negedge clk);
        cfg_we = 1'b0;
        if (int'(idx) < N) begin   // R11: out-of-range index leaves model unchanged
            m_en[idx] = en; m_val[idx] = v; m_msk[idx] = m; m_peer[idx] = p; m_mac[idx] = mac;
        end
    endtask

    task automatic lookup(input string tag, input logic [15:0] et, input logic [31:0] ip,
                          input logic [7:0] ttl, input int seed);
        logic [47:0] imac;
        logic [15:0] icsum;
        int          hi;
        logic [113:0] exp, act;
        imac  = 48'h0200_0000_0000 | 48'(seed);
        icsum = hdr_csum(ttl, seed);
        @(negedge clk);
        lk_strobe = 1'b1; lk_ethertype = et; lk_dst_ip = ip; lk_ttl = ttl;
        lk_csum = icsum; lk_dst_mac = imac;
        @(negedge clk);
        lk_strobe = 1'b0;
        hi = -1;
        for (int i = N - 1; i >= 0; i--)
            if (m_en[i] && (((ip ^ m_val[i]) & m_msk[i]) == 32'h0)) hi = i;
        if (et != 16'h0800 || hi < 0)
            exp = {1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, imac, ttl, icsum};
        else if (ttl <= 8'd1)
            exp = {1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, imac, ttl, icsum};
        else
            exp = {1'b1, 1'b1, 1'b0, 1'b0, 2'(hi), m_peer[hi], m_mac[hi], ttl - 8'd1,
                   hdr_csum(ttl - 8'd1, seed)};
        act = {res_valid, res_fast, res_slow, res_drop, res_entry, res_peer,
               res_dst_mac, res_ttl, res_csum};
        check(tag, act, exp);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_en[i] = 1'b0; m_val[i] = '0; m_msk[i] = '0; m_peer[i] = '0; m_mac[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset valid", {113'd0, res_valid}, 114'd0);

        // R1: empty table, everything slow
        for (int a = 0; a < 8; a++)
            lookup("R1", 16'h0800, {8'd10, 8'(a % 3), 8'(a), 8'd1}, 8'd64, a);

        write_entry(2'd0, 1'b1, 32'h0A01_0000, 32'hFFFF_0000, 2'd1, 48'hAAAA_0000_0001);
        write_entry(2'd1, 1'b1, 32'h0A02_0000, 32'hFFFF_0000, 2'd2, 48'hBBBB_0000_0002);
        write_entry(2'd2, 1'b1, 32'h0A01_0500, 32'hFFFF_FF00, 2'd3, 48'hCCCC_0000_0003);

        // R2/R4/R6/R7 address sweep
        for (int a = 0; a < 256; a++) begin
            logic [31:0] ip;
            ip = {8'd10, 8'(a & 3), 8'(((a >> 2) & 7) + 2), 8'(a)};
            lookup((((ip >> 16) == 32'h0A01) || ((ip >> 16) == 32'h0A02)) ? "R7 hit R2 R4"
                   : "R6 miss", 16'h0800, ip, 8'(2 + (a % 200)), a + 100);
        end

        // R8/R9 TTL sweep
        for (int t = 0; t < 256; t++)
            lookup(t <= 1 ? "R9 expire" : "R8 checksum", 16'h0800, 32'h0A02_0709, 8'(t), t * 7 + 3);
        for (int s = 0; s < 300; s++)
            lookup("R8 seed sweep", 16'h0800, 32'h0A01_0501, 8'(s % 254 + 2), s * 13 + 1);

        // R5 other ethertypes
        begin
            logic [15:0] ets [6] = '{16'h86DD, 16'h0806, 16'h0801, 16'h0000, 16'h8100, 16'h0008};
            for (int e = 0; e < 6; e++)
                lookup("R5 non-IPv4", ets[e], 32'h0A02_0101, 8'd40, e + 900);
        end

        // R10: no strobe, no valid
        @(negedge clk);
        check("R10 idle valid", {113'd0, res_valid}, 114'd0);

        // R3: disable entry 0, narrower entry 2 takes over
        write_entry(2'd0, 1'b0, 32'h0A01_0000, 32'hFFFF_0000, 2'd1, 48'hAAAA_0000_0001);
        lookup("R3 R4 disabled wide", 16'h0800, 32'h0A01_0509, 8'd9, 1001);
        lookup("R3 disabled miss", 16'h0800, 32'h0A01_0701, 8'd9, 1002);

        // R11: out-of-range write ignored
        write_entry(2'd3, 1'b1, 32'h0, 32'h0, 2'd3, 48'hDDDD_0000_0004);
        lookup("R11 ignored write", 16'h0800, 32'h0A09_0909, 8'd30, 1003);
        lookup("R11 table intact", 16'h0800, 32'h0A02_0303, 8'd30, 1004);

        // R2 catch-all mask, R4 lower index still wins
        write_entry(2'd1, 1'b1, 32'h1234_5678, 32'h0, 2'd2, 48'hEEEE_0000_0005);
        lookup("R2 catch-all", 16'h0800, 32'h0A09_0909, 8'd30, 1005);
        lookup("R2 catch-all", 16'h0800, 32'hC0A8_0001, 8'd2, 1006);
        lookup("R4 priority", 16'h0800, 32'h0A01_05FE, 8'd30, 1007);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule